// File: doc/BRIEF.md
# Per-Core Register Bank with Steerable Redirect Window

This block is a memory-mapped register space shared by several cores. Every core owns a private bank of per-core registers. A requesting core reaches its own bank through the local region. A shared global bank and a debug region sit beside it. A fourth region is a redirect window. Through the window the requester reaches a register at the same offset in some other target. That target is not chosen by address bits. It comes from a selector register that each requester keeps in its own bank, and it may name another core's bank, the global bank, or nothing.

Requests arrive on one valid/ready channel that carries the requester's core number. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The response appears one cycle later on a valid/ready channel. While a response waits, `req_ready` is low, so only one access is ever outstanding. A response that is held back by a low `rsp_ready` keeps its data unchanged until it is taken. Writes complete at the accept edge, so a selector change is in place for the next access.

Top module: `gcr_window_top`

## Requirements
- R1: After reset `rsp_valid` is low and `req_ready` is high. Every writable per-core register, every selector and the global scratch register read zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response is valid from the following cycle. `req_ready` is low while a response is pending. `rsp_rdata` stays stable until the edge where `rsp_ready` is high. A write returns 0 as its response data.
- R3: Address bits 14:13 select the region: 0 global, 1 local, 2 redirect window, 3 debug. Bits 12:0 give the offset within that region.
- R4: In a per-core bank, offset 0x028 is read-only identity. It returns the bank's core number in bits 7:0 and the parameter CLUSTER_ID in bits 15:8.
- R5: In a per-core bank, offset 0x008 keeps bits 7:0 and offset 0x020 keeps bits 31:12. All other bits of these two registers read zero.
- R6: The selector is at per-core offset 0x018. It keeps the target core in bits 13:8, the VP in bits 2:0 and the block kind in bits 25:24. All other bits read zero.
- R7: A window access uses the requester's own selector. With block kind 0 and a target core below NCORES, it reads and writes the target core's bank at the same offset.
- R8: With block kind 1 and a target core below NCORES, a window access reaches the global bank. The global bank holds core count NCORES in bits 7:0 of offset 0x000, a 32-bit scratch register at 0x008, and parameter REV in bits 15:0 of 0x030.
- R9: A target core value of 32 steers the window to the global bank, whatever the block kind.
- R10: Some window accesses have no target: a target core neither 32 nor below NCORES, or block kind 2 or 3. These read zero and discard writes. The same applies to debug-region accesses and to unmapped offsets.
- R11: Each requester has its own selector. Writing one requester's selector never changes where another requester's window points.
- R12: A selector write takes effect for the next accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | SRC_W | Core number of the requester |
| req_addr | input | 15 | Byte address in the register space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 32 | Read data; 0 for writes |

## Verification
The hardest case to reach from the ports is a window that lands on another core's bank. The change it makes shows up only when that other core reads its own local region. So the bench sweeps every requester, every target core from 0 to 7 plus the manager code 32, and all four block kinds. For each combination it programs the selector, writes and reads through the window, and then reads back the target's register as the target itself. That read-back shows whether the write landed in the right bank or was discarded. A separate sequence points two requesters at different cores to show that their selectors are independent. Another holds `rsp_ready` low to exercise back-pressure.

// File: rtl/gcr_window_pkg.sv
package gcr_window_pkg;
  localparam int ADDR_W = 15;
  localparam int OFS_W  = 13;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RGN_GLOBAL = 2'd0,
    RGN_LOCAL  = 2'd1,
    RGN_WINDOW = 2'd2,
    RGN_DEBUG  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    KIND_CORE   = 2'd0,
    KIND_SHARED = 2'd1,
    KIND_USER   = 2'd2,
    KIND_HIGH   = 2'd3
  } kind_e;

  localparam logic [5:0] CORE_MGR = 6'd32;

  localparam logic [OFS_W-1:0] OFS_COH   = 13'h008;
  localparam logic [OFS_W-1:0] OFS_SEL   = 13'h018;
  localparam logic [OFS_W-1:0] OFS_RBASE = 13'h020;
  localparam logic [OFS_W-1:0] OFS_IDENT = 13'h028;

  localparam logic [OFS_W-1:0] OFS_GCFG  = 13'h000;
  localparam logic [OFS_W-1:0] OFS_GSCR  = 13'h008;
  localparam logic [OFS_W-1:0] OFS_GREV  = 13'h030;
endpackage

// File: rtl/gcr_route.sv
module gcr_route
  import gcr_window_pkg::*;
#(
  parameter int NCORES = 4,
  localparam int SRC_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic [1:0]       region,
  input  logic [SRC_W-1:0] src,
  input  logic [5:0]       sel_core,
  input  logic [1:0]       sel_kind,
  output logic             to_global,
  output logic             to_core,
  output logic [SRC_W-1:0] tgt
);
  logic core_ok;
  assign core_ok = (int'(sel_core) < NCORES);

  always_comb begin
    to_global = 1'b0;
    to_core   = 1'b0;
    tgt       = src;
    unique case (region_e'(region))
      RGN_GLOBAL: to_global = 1'b1;
      RGN_LOCAL:  to_core   = 1'b1;
      RGN_WINDOW: begin
        tgt = sel_core[SRC_W-1:0];
        if (sel_core == CORE_MGR) begin
          to_global = 1'b1;
        end else if (core_ok) begin
          to_core   = (kind_e'(sel_kind) == KIND_CORE);
          to_global = (kind_e'(sel_kind) == KIND_SHARED);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gcr_core_bank.sv
module gcr_core_bank
  import gcr_window_pkg::*;
#(
  parameter int         CORE_NUM   = 0,
  parameter logic [7:0] CLUSTER_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [5:0]        sel_core,
  output logic [1:0]        sel_kind
);
  logic [7:0]  coh_q;
  logic [19:0] rbase_q;
  logic [5:0]  core_q;
  logic [1:0]  kind_q;
  logic [2:0]  vp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coh_q   <= '0;
      rbase_q <= '0;
      core_q  <= '0;
      kind_q  <= '0;
      vp_q    <= '0;
    end else if (wr_en) begin
      if (offset == OFS_COH)   coh_q   <= wdata[7:0];
      if (offset == OFS_RBASE) rbase_q <= wdata[31:12];
      if (offset == OFS_SEL) begin
        kind_q <= wdata[25:24];
        core_q <= wdata[13:8];
        vp_q   <= wdata[2:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (offset)
      OFS_COH:   rdata = {24'b0, coh_q};
      OFS_SEL:   rdata = {6'b0, kind_q, 10'b0, core_q, 5'b0, vp_q};
      OFS_RBASE: rdata = {rbase_q, 12'b0};
      OFS_IDENT: rdata = {16'b0, CLUSTER_ID, 8'(CORE_NUM)};
      default:   rdata = '0;
    endcase
  end

  assign sel_core = core_q;
  assign sel_kind = kind_q;
endmodule

// File: rtl/gcr_global_bank.sv
module gcr_global_bank
  import gcr_window_pkg::*;
#(
  parameter int          NCORES = 4,
  parameter logic [15:0] REV    = 16'h0900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] scr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scr_q <= '0;
    else if (wr_en && offset == OFS_GSCR) scr_q <= wdata;
  end

  always_comb begin
    unique case (offset)
      OFS_GCFG: rdata = {24'b0, 8'(NCORES)};
      OFS_GSCR: rdata = scr_q;
      OFS_GREV: rdata = {16'b0, REV};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gcr_window_top.sv
module gcr_window_top
  import gcr_window_pkg::*;
#(
  parameter int          NCORES     = 4,
  parameter logic [7:0]  CLUSTER_ID = 8'h05,
  parameter logic [15:0] REV        = 16'h0900,
  localparam int SRC_W = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [5:0]        sc  [NCORES];
  logic [1:0]        sk  [NCORES];
  logic [DATA_W-1:0] brd [NCORES];
  logic [DATA_W-1:0] grd;
  logic              to_global, to_core;
  logic [SRC_W-1:0]  tgt;
  logic              acc;
  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] rd;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign acc       = req_valid && req_ready;
  assign ofs       = req_addr[OFS_W-1:0];
  assign req_ready = !rsp_valid_q;

  gcr_route #(.NCORES(NCORES)) u_route (
    .region   (req_addr[ADDR_W-1:OFS_W]),
    .src      (req_src),
    .sel_core (sc[req_src]),
    .sel_kind (sk[req_src]),
    .to_global(to_global),
    .to_core  (to_core),
    .tgt      (tgt)
  );

  for (genvar i = 0; i < NCORES; i++) begin : g_bank
    gcr_core_bank #(.CORE_NUM(i), .CLUSTER_ID(CLUSTER_ID)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc && req_write && to_core && (int'(tgt) == i)),
      .offset  (ofs),
      .wdata   (req_wdata),
      .rdata   (brd[i]),
      .sel_core(sc[i]),
      .sel_kind(sk[i])
    );
  end

  gcr_global_bank #(.NCORES(NCORES), .REV(REV)) u_global (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (acc && req_write && to_global),
    .offset(ofs),
    .wdata (req_wdata),
    .rdata (grd)
  );

  always_comb begin
    if (req_write)      rd = '0;
    else if (to_global) rd = grd;
    else if (to_core)   rd = brd[tgt];
    else                rd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (acc) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= rd;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/gcr_window_chk.sv
module gcr_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata
);
  // R2
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R2
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R1
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
endmodule

bind gcr_window_top gcr_window_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata)
);

// File: tb/gcr_window_top_bench.sv
module gcr_window_top_bench;
  localparam int NC = 4;
  localparam logic [7:0]  CL  = 8'h05;
  localparam logic [15:0] RV  = 16'h0900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_src = '0;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  m_coh  [NC];
  logic [19:0] m_rb   [NC];
  logic [5:0]  m_core [NC];
  logic [1:0]  m_kind [NC];
  logic [2:0]  m_vp   [NC];
  logic [31:0] m_gscr;

  always #5 clk = ~clk;

  gcr_window_top #(.NCORES(NC), .CLUSTER_ID(CL), .REV(RV)) u_gcr_window_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_src(req_src), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // resolve target from requirements R3, R7-R10: 0 none, 1 global, 2 core
  function automatic int resolve(input int s, input logic [14:0] a, output int t);
    int c;
    t = s;
    case (a[14:13])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: begin
        c = int'(m_core[s]);
        t = c;
        if (c == 32) return 1;
        if (c >= NC) return 0;
        if (m_kind[s] == 2'd0) return 2;
        if (m_kind[s] == 2'd1) return 1;
        return 0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int s, input logic [14:0] a);
    int t, r;
    logic [12:0] o;
    o = a[12:0];
    r = resolve(s, a, t);
    if (r == 1) begin
      if (o == 13'h000) return 32'(NC);
      if (o == 13'h008) return m_gscr;
      if (o == 13'h030) return {16'b0, RV};
      return 0;
    end
    if (r == 2) begin
      if (o == 13'h008) return {24'b0, m_coh[t]};
      if (o == 13'h018) return {6'b0, m_kind[t], 10'b0, m_core[t], 5'b0, m_vp[t]};
      if (o == 13'h020) return {m_rb[t], 12'b0};
      if (o == 13'h028) return {16'b0, CL, 8'(t)};
    end
    return 0;
  endfunction

  task automatic m_write(input int s, input logic [14:0] a, input logic [31:0] d);
    int t, r;
    logic [12:0] o;
    o = a[12:0];
    r = resolve(s, a, t);
    if (r == 1 && o == 13'h008) m_gscr = d;
    if (r == 2) begin
      if (o == 13'h008) m_coh[t] = d[7:0];
      if (o == 13'h020) m_rb[t] = d[31:12];
      if (o == 13'h018) begin
        m_kind[t] = d[25:24]; m_core[t] = d[13:8]; m_vp[t] = d[2:0];
      end
    end
  endtask

  task automatic bus(input int s, input bit wr, input logic [14:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_src = 2'(s); req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
    check("R2 rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
    @(posedge clk);
  endtask

  task automatic wr(input int s, input logic [14:0] a, input logic [31:0] d, input string req);
    logic [31:0] q;
    bus(s, 1'b1, a, d, q);
    check({req, " write rdata"}, q, 32'h0);
    m_write(s, a, d);
  endtask

  task automatic rd(input int s, input logic [14:0] a, input string req);
    logic [31:0] q;
    bus(s, 1'b0, a, 32'h0, q);
    check(req, q, m_read(s, a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    for (int i = 0; i < NC; i++) begin
      m_coh[i] = 0; m_rb[i] = 0; m_core[i] = 0; m_kind[i] = 0; m_vp[i] = 0;
    end
    m_gscr = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 rsp_valid reset", {31'b0, rsp_valid}, 32'd0);
    check("R1 req_ready reset", {31'b0, req_ready}, 32'd1);
    for (int s = 0; s < NC; s++) begin
      rd(s, 15'h2008, "R1 coh reset");
      rd(s, 15'h2018, "R1 sel reset");
      rd(s, 15'h2020, "R1 rbase reset");
      rd(s, 15'h2028, "R4 identity");
    end
    rd(0, 15'h0008, "R1 gscr reset");
    rd(0, 15'h0000, "R8 global config");
    rd(0, 15'h0030, "R8 global rev");
    // R5 masks, R6 selector mask
    for (int s = 0; s < NC; s++) begin
      wr(s, 15'h2008, 32'hFFFF_FF00 | 32'(s + 8'h3C), "R5");
      rd(s, 15'h2008, "R5 coh mask");
      wr(s, 15'h2020, 32'hFFFF_FFFF - 32'(s), "R5");
      rd(s, 15'h2020, "R5 rbase mask");
      wr(s, 15'h2018, 32'hFFFF_FFFF, "R6");
      rd(s, 15'h2018, "R6 selector mask");
    end
    // R3 debug region and unmapped offsets
    rd(1, 15'h6008, "R10 debug region");
    rd(1, 15'h2010, "R10 unmapped local");
    rd(1, 15'h0010, "R10 unmapped global");
    wr(0, 15'h0008, 32'hA5A5_0001, "R8");
    rd(2, 15'h0008, "R3 global scratch");
    // sweep: R7 R8 R9 R10 R12
    for (int s = 0; s < NC; s++) begin
      for (int ci = 0; ci < 9; ci++) begin
        for (int k = 0; k < 4; k++) begin
          int c;
          logic [31:0] v;
          c = (ci == 8) ? 32 : ci;
          wr(s, 15'h2018, (32'(k) << 24) | (32'(c) << 8) | 32'(s), "R12");
          v = 32'h1000_0000 ^ (32'(s) << 16) ^ (32'(c) << 4) ^ 32'(k);
          wr(s, 15'h4008, v, "R7");
          rd(s, 15'h4008, "R7 window readback");
          rd(s, 15'h4028, "R7 window identity");
          rd(s, 15'h4000, "R8 window config");
          for (int t = 0; t < NC; t++) rd(t, 15'h2008, "R10 target bank after window write");
          rd(s, 15'h0008, "R9 global scratch after window write");
        end
      end
    end
    // R11 independence
    wr(0, 15'h2018, 32'h0000_0100, "R11");
    wr(1, 15'h2018, 32'h0000_0200, "R11");
    wr(0, 15'h4020, 32'hDEAD_B000, "R11");
    rd(1, 15'h2020, "R11 core1 changed via requester 0");
    rd(2, 15'h2020, "R11 core2 untouched");
    rd(1, 15'h4020, "R11 requester 1 window still on core2");
    rd(0, 15'h4018, "R11 window into selector");
    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_src = 2'd3; req_addr = 15'h2028;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 3; n++) begin
      check("R2 held valid", {31'b0, rsp_valid}, 32'd1);
      check("R2 req_ready low while pending", {31'b0, req_ready}, 32'd0);
      check("R2 held data", rsp_rdata, {16'b0, CL, 8'd3});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R2 released", {31'b0, rsp_valid}, 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule